// File: doc/BRIEF.md
# Per-CPU Interrupt Mailbox

This block keeps one mailbox per CPU for interrupts that arrive from an external bus. A request names a target CPU, a source ID and two data words. When the target's mailbox is free, the block answers with an accept in the same cycle. It records the source and both words, marks the mailbox busy, and one cycle later posts a shared, software-programmed vector to that CPU. When the mailbox is busy the request is refused, and the sender retries later.

Software uses a single register port with one cycle of read latency. Indexed windows give access to every mailbox's word 0, word 1 and status. A small group of own-CPU aliases picks the mailbox from the requester's CPU number instead of from the address. The same group holds the shared vector register. Software releases a mailbox by writing its status register.

Register addresses are byte addresses. Bits [2:0] are ignored. Bits [CPU_W+2:3] form an index. Bits [CPU_W+4:CPU_W+3] select a region: 0 is word 0 by index, 1 is word 1 by index, 2 is status by index, and 3 is the own-CPU group. In the own-CPU group, index 0 is own word 0, 1 is own word 1, 2 is own status and 3 is the vector register. CPU_W is the width of a CPU number.

Top module: `irq_mailbox`

## Requirements
- R1: After reset every mailbox is free with source 0, the vector register is 0, post_valid is 0 and reg_rdata is 0.
- R2: A request to an in-range CPU whose mailbox is free raises irq_accept in the same cycle. That mailbox reads busy from the next cycle on.
- R3: A request to a busy mailbox sees irq_accept low. The stored source and data words of that mailbox stay unchanged.
- R4: On acceptance, irq_word0 and irq_word1 are stored. They read back through regions 0 and 1 at the target's index.
- R5: One cycle after an accept, post_valid is 1 for exactly one cycle. post_cpu is the accepted target and post_vec is the vector register value from the accept cycle.
- R6: A status read returns busy at bit 5 and the source ID in bits 4:0, with all other bits 0.
- R7: A status write loads busy from bit 5 of the write data. All other bits are ignored and the stored source is kept.
- R8: When a status write that clears busy and a request for the same CPU fall in the same cycle, the clear takes effect first and the request is accepted.
- R9: Own-CPU aliases 0, 1 and 2 read word 0, word 1 and status, and write status, of the mailbox numbered by reg_cpu.
- R10: A request with a target at or above NUM_CPU is refused. A read whose resolved index is at or above NUM_CPU returns 0.
- R11: Writes to regions 0 and 1 and to aliases 0 and 1 leave the stored words unchanged.
- R12: A write to alias 3 loads the vector register from the low VEC_W bits. A read of alias 3 returns it zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_valid | input | 1 | Incoming interrupt request |
| irq_cpu | input | CPU_W | Target CPU of the request |
| irq_src | input | SRC_W | Source ID of the request |
| irq_word0 | input | DATA_W | First data word |
| irq_word1 | input | DATA_W | Second data word |
| irq_accept | output | 1 | Request taken (same cycle); low means retry |
| post_valid | output | 1 | Interrupt posted to a CPU |
| post_cpu | output | CPU_W | CPU being interrupted |
| post_vec | output | VEC_W | Vector delivered |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 write, 0 read |
| reg_addr | input | CPU_W+5 | Byte address |
| reg_cpu | input | CPU_W | CPU number of the requester, used by aliases |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after a read |

## Verification
The bench builds the block with NUM_CPU = 6, which is not a power of two. The 3-bit CPU numbers 6 and 7 can then be driven on both the request side and the register side, so out-of-range refusal and zeroed reads get exercised. SRC_W = 5, VEC_W = 6 and DATA_W = 64 keep the status layout and the full-width data paths at their real sizes. With only six mailboxes, random requests and random busy writes meet busy mailboxes, same-cycle clears and alias collisions often.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
  typedef enum logic [1:0] {
    RG_WORD0 = 2'd0,
    RG_WORD1 = 2'd1,
    RG_STAT  = 2'd2,
    RG_OWN   = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_RAM  = 2'd1,
    RD_STAT = 2'd2,
    RD_VEC  = 2'd3
  } rdkind_e;

  localparam int BUSY_BIT = 5;
endpackage

// File: rtl/mbx_wordram.sv
`timescale 1ns/1ps
module mbx_wordram #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 64,
  parameter int AW    = 5
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/mbx_state.sv
`timescale 1ns/1ps
module mbx_state #(
  parameter int NUM_CPU = 32,
  parameter int SRC_W   = 5,
  parameter int CPU_W   = 5
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              irq_valid,
  input  logic [CPU_W-1:0]                  irq_cpu,
  input  logic [SRC_W-1:0]                  irq_src,
  input  logic                              sw_wr,
  input  logic [CPU_W-1:0]                  sw_idx,
  input  logic                              sw_busy,
  output logic                              accept,
  output logic [NUM_CPU-1:0]                busy_q,
  output logic [NUM_CPU-1:0][SRC_W-1:0]     src_q
);
  localparam logic [CPU_W:0] NCPU_L = (CPU_W+1)'(NUM_CPU);

  logic in_range;
  logic cur_busy;

  always_comb begin
    in_range = {1'b0, irq_cpu} < NCPU_L;
    cur_busy = in_range ? busy_q[irq_cpu] : 1'b1;
    if (sw_wr && sw_idx == irq_cpu) cur_busy = sw_busy;
    accept = irq_valid && in_range && !cur_busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= '0;
      src_q  <= '0;
    end else begin
      for (int i = 0; i < NUM_CPU; i++) begin
        if (accept && irq_cpu == CPU_W'(i)) begin
          busy_q[i] <= 1'b1;
          src_q[i]  <= irq_src;
        end else if (sw_wr && sw_idx == CPU_W'(i)) begin
          busy_q[i] <= sw_busy;
        end
      end
    end
  end

  p_refuse_busy_r3: assert property (@(posedge clk) disable iff (rst)
    accept |-> (!busy_q[irq_cpu] || (sw_wr && sw_idx == irq_cpu && !sw_busy)));
  p_src_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(src_q));
  p_busy_set_r2: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy_q[$past(irq_cpu)]);
  p_out_of_range_r10: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && !({1'b0, irq_cpu} < NCPU_L)) |-> !accept);
  p_clear_first_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && in_range && sw_wr && sw_idx == irq_cpu && !sw_busy) |-> accept);
endmodule

// File: rtl/mbx_regif.sv
`timescale 1ns/1ps
module mbx_regif
  import mbx_pkg::*;
#(
  parameter int NUM_CPU = 32,
  parameter int SRC_W   = 5,
  parameter int DATA_W  = 64,
  parameter int VEC_W   = 6,
  parameter int CPU_W   = 5,
  parameter int ADDR_W  = 10
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          reg_en,
  input  logic                          reg_we,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic [CPU_W-1:0]              reg_cpu,
  input  logic [DATA_W-1:0]             reg_wdata,
  input  logic [NUM_CPU-1:0]            busy_q,
  input  logic [NUM_CPU-1:0][SRC_W-1:0] src_q,
  input  logic [1:0][DATA_W-1:0]        ram_rdata,
  output logic                          ram_re,
  output logic [CPU_W-1:0]              ram_raddr,
  output logic                          sw_wr,
  output logic [CPU_W-1:0]              sw_idx,
  output logic                          sw_busy,
  output logic [VEC_W-1:0]              vec_q,
  output logic [DATA_W-1:0]             reg_rdata
);
  localparam logic [CPU_W:0] NCPU_L = (CPU_W+1)'(NUM_CPU);

  region_e          region;
  logic [CPU_W-1:0] idx, eff_idx;
  logic             is_ram, word_sel, is_stat, is_vec, idx_ok, rd, wr;

  rdkind_e          kind_q;
  logic             sel_q, stat_busy_q;
  logic [SRC_W-1:0] stat_src_q;

  logic unused_bits;
  assign unused_bits = ^{reg_addr[2:0], reg_wdata};

  always_comb begin
    region   = region_e'(reg_addr[CPU_W+4:CPU_W+3]);
    idx      = reg_addr[CPU_W+2:3];
    eff_idx  = (region == RG_OWN) ? reg_cpu : idx;
    is_ram   = 1'b0;
    word_sel = 1'b0;
    is_stat  = 1'b0;
    is_vec   = 1'b0;
    unique case (region)
      RG_WORD0: is_ram = 1'b1;
      RG_WORD1: begin is_ram = 1'b1; word_sel = 1'b1; end
      RG_STAT:  is_stat = 1'b1;
      RG_OWN: begin
        if (idx == CPU_W'(0)) is_ram = 1'b1;
        if (idx == CPU_W'(1)) begin is_ram = 1'b1; word_sel = 1'b1; end
        if (idx == CPU_W'(2)) is_stat = 1'b1;
        if (idx == CPU_W'(3)) is_vec = 1'b1;
      end
    endcase
    idx_ok    = {1'b0, eff_idx} < NCPU_L;
    rd        = reg_en && !reg_we;
    wr        = reg_en && reg_we;
    ram_re    = rd && is_ram && idx_ok;
    ram_raddr = eff_idx;
    sw_wr     = wr && is_stat && idx_ok;
    sw_idx    = eff_idx;
    sw_busy   = reg_wdata[BUSY_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q      <= RD_NONE;
      sel_q       <= 1'b0;
      stat_busy_q <= 1'b0;
      stat_src_q  <= '0;
      vec_q       <= '0;
    end else begin
      kind_q <= RD_NONE;
      if (rd && is_vec)                kind_q <= RD_VEC;
      else if (rd && is_ram && idx_ok) kind_q <= RD_RAM;
      else if (rd && is_stat && idx_ok) begin
        kind_q      <= RD_STAT;
        stat_busy_q <= busy_q[eff_idx];
        stat_src_q  <= src_q[eff_idx];
      end
      sel_q <= word_sel;
      if (wr && is_vec) vec_q <= reg_wdata[VEC_W-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (kind_q)
      RD_RAM:  reg_rdata = ram_rdata[sel_q];
      RD_STAT: begin
        reg_rdata[BUSY_BIT]  = stat_busy_q;
        reg_rdata[SRC_W-1:0] = stat_src_q;
      end
      RD_VEC:  reg_rdata[VEC_W-1:0] = vec_q;
      default: reg_rdata = '0;
    endcase
  end

  p_vec_load_r12: assert property (@(posedge clk) disable iff (rst)
    (wr && is_vec) |=> vec_q == $past(reg_wdata[VEC_W-1:0]));
  p_oob_read_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (rd && !is_vec && !idx_ok) |=> reg_rdata == '0);
endmodule

// File: rtl/irq_mailbox.sv
`timescale 1ns/1ps
module irq_mailbox #(
  parameter int NUM_CPU = 32,
  parameter int SRC_W   = 5,
  parameter int DATA_W  = 64,
  parameter int VEC_W   = 6,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int ADDR_W = CPU_W + 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_valid,
  input  logic [CPU_W-1:0]  irq_cpu,
  input  logic [SRC_W-1:0]  irq_src,
  input  logic [DATA_W-1:0] irq_word0,
  input  logic [DATA_W-1:0] irq_word1,
  output logic              irq_accept,
  output logic              post_valid,
  output logic [CPU_W-1:0]  post_cpu,
  output logic [VEC_W-1:0]  post_vec,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CPU_W-1:0]  reg_cpu,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  logic [NUM_CPU-1:0]            busy_q;
  logic [NUM_CPU-1:0][SRC_W-1:0] src_q;
  logic                          sw_wr, sw_busy, ram_re;
  logic [CPU_W-1:0]              sw_idx, ram_raddr;
  logic [VEC_W-1:0]              vec_q;
  logic [1:0][DATA_W-1:0]        irq_words, ram_rdata;

  assign irq_words = {irq_word1, irq_word0};

  mbx_state #(.NUM_CPU(NUM_CPU), .SRC_W(SRC_W), .CPU_W(CPU_W)) u_state (
    .clk(clk), .rst(rst), .irq_valid(irq_valid), .irq_cpu(irq_cpu),
    .irq_src(irq_src), .sw_wr(sw_wr), .sw_idx(sw_idx), .sw_busy(sw_busy),
    .accept(irq_accept), .busy_q(busy_q), .src_q(src_q)
  );

  for (genvar w = 0; w < 2; w++) begin : g_word
    mbx_wordram #(.DEPTH(NUM_CPU), .WIDTH(DATA_W), .AW(CPU_W)) u_ram (
      .clk(clk), .we(irq_accept), .waddr(irq_cpu), .wdata(irq_words[w]),
      .re(ram_re), .raddr(ram_raddr), .rdata(ram_rdata[w])
    );
  end

  mbx_regif #(.NUM_CPU(NUM_CPU), .SRC_W(SRC_W), .DATA_W(DATA_W), .VEC_W(VEC_W),
              .CPU_W(CPU_W), .ADDR_W(ADDR_W)) u_regif (
    .clk(clk), .rst(rst), .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_cpu(reg_cpu), .reg_wdata(reg_wdata), .busy_q(busy_q), .src_q(src_q),
    .ram_rdata(ram_rdata), .ram_re(ram_re), .ram_raddr(ram_raddr),
    .sw_wr(sw_wr), .sw_idx(sw_idx), .sw_busy(sw_busy), .vec_q(vec_q),
    .reg_rdata(reg_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      post_valid <= 1'b0;
      post_cpu   <= '0;
      post_vec   <= '0;
    end else begin
      post_valid <= irq_accept;
      post_cpu   <= irq_cpu;
      post_vec   <= vec_q;
    end
  end

  p_post_after_accept_r5: assert property (@(posedge clk) disable iff (rst)
    irq_accept |=> (post_valid && post_cpu == $past(irq_cpu)));
  p_no_post_without_accept_r5: assert property (@(posedge clk) disable iff (rst)
    !irq_accept |=> !post_valid);
endmodule

// File: tb/irq_mailbox_test.sv
`timescale 1ns/1ps
module irq_mailbox_test;
  localparam int NC = 6;
  localparam int CW = 3;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic irq_valid = 0, irq_accept, post_valid, reg_en = 0, reg_we = 0;
  logic [CW-1:0] irq_cpu = '0, post_cpu, reg_cpu = '0;
  logic [4:0] irq_src = '0;
  logic [63:0] irq_word0 = '0, irq_word1 = '0, reg_wdata = '0, reg_rdata;
  logic [5:0] post_vec;
  logic [AW-1:0] reg_addr = '0;

  int checks = 0;
  int fails = 0;

  bit         m_busy [8];
  logic [4:0]  m_src [8];
  logic [63:0] m_w0 [8];
  logic [63:0] m_w1 [8];
  logic [5:0]  m_vec;

  always #2.5 clk = ~clk;

  irq_mailbox #(.NUM_CPU(NC), .SRC_W(5), .DATA_W(64), .VEC_W(6)) uut (
    .clk(clk), .rst(rst), .irq_valid(irq_valid), .irq_cpu(irq_cpu),
    .irq_src(irq_src), .irq_word0(irq_word0), .irq_word1(irq_word1),
    .irq_accept(irq_accept), .post_valid(post_valid), .post_cpu(post_cpu),
    .post_vec(post_vec), .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_cpu(reg_cpu), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [AW-1:0] mk_addr(int region, int idx);
    return {region[1:0], idx[2:0], 3'($urandom % 8)};
  endfunction

  // kind: 0 none, 1 word0, 2 word1, 3 status, 4 vector
  function automatic int kind_of(logic [AW-1:0] a);
    int r = int'(a[7:6]);
    int i = int'(a[5:3]);
    if (r < 3) return r + 1;
    if (i < 4) return i + 1;
    return 0;
  endfunction

  function automatic int eff_of(logic [AW-1:0] a, logic [CW-1:0] rc);
    return (a[7:6] == 2'd3) ? int'(rc) : int'(a[5:3]);
  endfunction

  function automatic logic [63:0] exp_read(logic [AW-1:0] a, logic [CW-1:0] rc);
    int k = kind_of(a);
    int e = eff_of(a, rc);
    if (k == 4) return {58'd0, m_vec};
    if (k == 0 || e >= NC) return 64'd0;
    if (k == 1) return m_w0[e];
    if (k == 2) return m_w1[e];
    return {58'd0, m_busy[e], m_src[e]};
  endfunction

  function automatic string read_tag(logic [AW-1:0] a);
    if (a[7:6] == 2'd3) return "R9";
    if (kind_of(a) == 3) return "R6";
    return "R4";
  endfunction

  task automatic idle();
    irq_valid = 0; reg_en = 0; reg_we = 0;
  endtask

  // inputs are set just after a negedge; checks one full cycle
  task automatic step(string rtag);
    bit sw_hit, eff_busy, exp_acc, rd;
    int  k, e, c;
    logic [63:0] er;
    logic [5:0] ev;
    logic [CW-1:0] ec;
    string atag;
    #1;
    k = kind_of(reg_addr);
    e = eff_of(reg_addr, reg_cpu);
    c = int'(irq_cpu);
    sw_hit = reg_en && reg_we && k == 3 && e < NC && e == c;
    eff_busy = sw_hit ? reg_wdata[5] : m_busy[c];
    exp_acc = irq_valid && c < NC && !eff_busy;
    if (irq_valid && c >= NC) atag = "R10";
    else if (irq_valid && sw_hit && !reg_wdata[5]) atag = "R8";
    else if (irq_valid && m_busy[c]) atag = "R3";
    else atag = "R2";
    check(atag, 64'(irq_accept), 64'(exp_acc));
    rd = reg_en && !reg_we;
    er = exp_read(reg_addr, reg_cpu);
    if (rtag == "") rtag = read_tag(reg_addr);
    ev = m_vec;
    ec = irq_cpu;
    if (reg_en && reg_we) begin
      if (k == 3 && e < NC) m_busy[e] = reg_wdata[5];
      if (k == 4) m_vec = reg_wdata[5:0];
    end
    if (exp_acc) begin
      m_busy[c] = 1;
      m_src[c] = irq_src;
      m_w0[c] = irq_word0;
      m_w1[c] = irq_word1;
    end
    @(negedge clk);
    check("R5", 64'(post_valid), 64'(exp_acc));
    if (exp_acc) begin
      check("R5", 64'(post_cpu), 64'(ec));
      check("R5", 64'(post_vec), 64'(ev));
    end
    if (rd) check(rtag, reg_rdata, er);
    idle();
  endtask

  task automatic do_read(logic [AW-1:0] a, logic [CW-1:0] rc, string tag);
    reg_en = 1; reg_we = 0; reg_addr = a; reg_cpu = rc;
    step(tag);
  endtask

  task automatic do_write(logic [AW-1:0] a, logic [CW-1:0] rc, logic [63:0] d);
    reg_en = 1; reg_we = 1; reg_addr = a; reg_cpu = rc; reg_wdata = d;
    step("");
  endtask

  task automatic set_irq(int cpu, logic [4:0] s, logic [63:0] a, logic [63:0] b);
    irq_valid = 1; irq_cpu = CW'(cpu); irq_src = s; irq_word0 = a; irq_word1 = b;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: run did not complete (all requirements)");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) begin
      m_busy[i] = 0; m_src[i] = '0; m_w0[i] = '0; m_w1[i] = '0;
    end
    m_vec = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    check("R1", 64'(post_valid), 64'd0);
    check("R1", reg_rdata, 64'd0);
    for (int i = 0; i < NC; i++) do_read(mk_addr(2, i), '0, "R1");
    do_read(mk_addr(3, 3), '0, "R1");

    // R12: vector register, upper bits dropped
    do_write(mk_addr(3, 3), '0, 64'hFFFF_0000_0000_FFEA);
    do_read(mk_addr(3, 3), '0, "R12");

    // R2/R5: accept into free mailbox 2
    set_irq(2, 5'd7, 64'h1111_2222_3333_4444, 64'hAAAA_BBBB_CCCC_DDDD);
    step("");
    do_read(mk_addr(0, 2), '0, "R4");
    do_read(mk_addr(1, 2), '0, "R4");
    do_read(mk_addr(2, 2), '0, "R6");

    // R3: busy refusal keeps contents
    set_irq(2, 5'd19, 64'hDEAD, 64'hBEEF);
    step("");
    do_read(mk_addr(0, 2), '0, "R3");
    do_read(mk_addr(2, 2), '0, "R3");

    // R11: data windows ignore writes
    do_write(mk_addr(0, 2), '0, 64'h5555);
    do_write(mk_addr(3, 1), 3'd2, 64'h6666);
    do_read(mk_addr(0, 2), '0, "R11");
    do_read(mk_addr(1, 2), '0, "R11");

    // R9: aliases resolve through reg_cpu
    do_read(mk_addr(3, 0), 3'd2, "R9");
    do_read(mk_addr(3, 1), 3'd2, "R9");
    do_read(mk_addr(3, 2), 3'd2, "R9");
    do_read(mk_addr(3, 2), 3'd4, "R9");

    // R8: clear and request for the same CPU in one cycle
    reg_en = 1; reg_we = 1; reg_addr = mk_addr(2, 2); reg_wdata = 64'h1F;
    set_irq(2, 5'd9, 64'h77, 64'h88);
    step("");
    do_read(mk_addr(2, 2), '0, "R8");

    // R10: out-of-range targets and reads
    set_irq(6, 5'd1, 64'h1, 64'h2);
    step("");
    set_irq(7, 5'd1, 64'h1, 64'h2);
    step("");
    do_read(mk_addr(2, 7), '0, "R10");
    do_read(mk_addr(0, 6), '0, "R10");
    do_read(mk_addr(3, 0), 3'd7, "R10");

    // R7: release via own status alias, other bits ignored
    do_write(mk_addr(3, 2), 3'd2, 64'hFFFF_FFFF_FFFF_FFDF);
    do_read(mk_addr(2, 2), '0, "R7");
    do_write(mk_addr(2, 4), '0, 64'h20);
    do_read(mk_addr(2, 4), '0, "R7");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      if ($urandom % 2 == 1)
        set_irq(int'($urandom % 8), 5'($urandom), {$urandom, $urandom}, {$urandom, $urandom});
      if ($urandom % 2 == 1) begin
        reg_en = 1;
        reg_we = ($urandom % 3 == 0);
        reg_addr = mk_addr(int'($urandom % 4), int'($urandom % 8));
        reg_cpu = CW'($urandom % 8);
        reg_wdata = {$urandom, $urandom};
      end
      step("");
    end

    summary();
    $finish;
  end
endmodule